// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block is a register-mapped timer with five independent channels. Each channel holds a down counter that is loaded from a count buffer. It ticks at a rate set by one of two shared 8-bit prescalers and by a per-channel power-of-two divider. When the counter reaches zero it raises a sticky status bit. It then either reloads from its buffer and keeps running, or it stops. Channels 0 to 3 also drive a PWM level: the level is high while the live count exceeds a live compare value, and an invert bit can flip it. Channel 4 is a pure timer with no output and no compare.

Software uses a 32-bit single-cycle register bus. It writes the buffers and then pulses the per-channel manual-update bit, which copies the buffers into the live registers for as long as the bit is held. It then sets start, with or without auto-reload. Reads are combinational and have no side effects. Interrupt lines are level outputs, one per channel.

Each channel is sequenced by a four-state machine:
- CH_IDLE: start is clear.
- CH_LOAD: manual update is held.
- CH_RUN: the channel is counting.
- CH_DONE: a one-shot count has expired.

The transitions are:
- Manual update in any state leads to CH_LOAD.
- With manual update clear, start clear in any state leads to CH_IDLE.
- With start set, CH_IDLE or CH_LOAD moves to CH_RUN.
- CH_RUN moves to CH_DONE on a zero tick when auto-reload is clear.
- CH_DONE holds until start clears or manual update is set.

Top module: `quint_pwm_timer`

## Requirements
- R1: After reset every register reads 0, every live count is 0, and irq_o and pwm_o are all 0.
- R2: While a channel's manual-update bit is 1, its live count (and, for channels 0-3, its live compare value) is reloaded from the buffers on every clock, and the counter does not decrement even if start is 1.
- R3: With start 1 and manual update 0, the counter decrements by one on each channel tick. A tick that finds the count at 0 sets the channel's status bit on the following edge. With a tick every cycle, a count of N written before start makes status read 1 exactly N+2 clock edges after the edge that writes start.
- R4: On a zero tick with auto-reload 1, the count reloads from the count buffer and counting continues. With auto-reload 0, the count stays at 0 and no further decrement happens.
- R5: Config register 0x00 bits [7:0] hold prescaler A, used by channels 0 and 1. Bits [15:8] hold prescaler B, used by channels 2, 3 and 4. A value v divides the clock by v+1.
- R6: Config register 0x04 holds a 4-bit divider field for channel n at bits [4n+3:4n]. A field value k divides the prescaled rate by 2^k. Values above DIV_LOG2_MAX act as DIV_LOG2_MAX.
- R7: In the control register at 0x08, channel 0 uses bits [3:0] and channel n≥1 uses bits [4n+7:4n+4]. In each group, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. For channel 4, auto-reload is group bit 2 and there is no invert. Bits [7:4] and [31:23] read 0.
- R8: In the register at 0x44, bits [4:0] are interrupt enables (written as plain values) and bits [9:5] are status bits. Writing 1 to a status bit clears it and writing 0 leaves it. Status is sticky, and a zero tick in the same cycle as a clear leaves the bit at 1.
- R9: irq_o[n] is 1 exactly when enable bit n and status bit n are both 1.
- R10: For channels 0-3, pwm_o[n] is 1 when the live count is strictly greater than the live compare value, and the invert bit flips it.
- R11: The count buffer of channel n is at 0x0C+12n and the compare buffer of channel n<4 is at 0x10+12n. The live count of channel n<4 reads at 0x14+12n and that of channel 4 at 0x40. The live-count addresses are read-only: writes to them change no register.
- R12: Clearing start freezes the live count at its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 5 | Per-channel interrupt level |
| pwm_o | output | 4 | PWM level of channels 0-3 |

## Verification
The bench builds the timer with CNT_W=16 and DIV_LOG2_MAX=4. With these values the divider clamp is reachable: a field of 15 gives a 32-cycle period at a count of 1 and no prescale, so it can be measured exactly. Small prescaler values (0 and 2) keep every PWM period under 100 cycles. This lets the bench check the exact periods that follow from prescaler, divider and count, and the per-group split of the prescalers. The 16-bit count width lets the bench use distinct buffer patterns for each channel when checking the address map.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
    localparam int NCH  = 5;
    localparam int NPWM = 4;

    typedef enum logic [1:0] {CH_IDLE, CH_LOAD, CH_RUN, CH_DONE} ch_state_e;

    typedef struct packed {
        logic start;
        logic manual;
        logic reload;
    } ch_ctrl_t;

    localparam logic [7:0] A_CFG0 = 8'h00;
    localparam logic [7:0] A_CFG1 = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_IRQ  = 8'h44;
    localparam logic [31:0] CTRL_MASK = 32'h007F_FF0F;

    function automatic logic [7:0] cnt_buf_addr(int n);
        return 8'(12 * n + 12);
    endfunction

    function automatic logic [7:0] cmp_buf_addr(int n);
        return 8'(12 * n + 16);
    endfunction

    function automatic logic [7:0] obs_addr(int n);
        return (n == NCH - 1) ? 8'h40 : 8'(12 * n + 20);
    endfunction

    // channel 0 sits at bit 0, later channels skip one nibble
    function automatic int ctrl_base(int n);
        return (n == 0) ? 0 : 4 * (n + 1);
    endfunction

    function automatic int grp_sel(int n);
        return (n < 2) ? 0 : 1;
    endfunction
endpackage

// File: rtl/qpt_tick_gen.sv
module qpt_tick_gen #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_val,
    output logic             pre_tick,
    output logic [DIV_W-1:0] div_cnt
);
    logic [PRE_W-1:0] pcnt;

    // >= so that lowering pre_val mid-count never strands the counter
    assign pre_tick = (pcnt >= pre_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt    <= '0;
            div_cnt <= '0;
        end else if (pre_tick) begin
            pcnt    <= '0;
            div_cnt <= div_cnt + 1'b1;
        end else begin
            pcnt    <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/qpt_channel.sv
module qpt_channel
    import qpt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ch_ctrl_t         cc,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic             pre_tick,
    input  logic [DIV_W-1:0] div_cnt,
    input  logic [3:0]       div_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             tick,
    output logic             zero_evt,
    output logic             running
);
    localparam int SW = DIV_W + 1;

    ch_state_e        state, state_nxt;
    logic [SW-1:0]    sel_c;
    logic [SW-1:0]    one_hot;
    logic [DIV_W-1:0] mask;

    // divided tick: every 2^sel pre-ticks, sel clamped to DIV_W
    always_comb begin
        sel_c   = (32'(div_sel) > DIV_W) ? SW'(DIV_W) : SW'(div_sel);
        one_hot = SW'(1) << sel_c;
        mask    = DIV_W'(one_hot - 1'b1);
        tick    = pre_tick && ((div_cnt & mask) == mask);
    end

    assign running  = (state == CH_RUN) && cc.start && !cc.manual;
    assign zero_evt = running && tick && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (cc.manual) begin
            state_nxt = CH_LOAD;
        end else if (!cc.start) begin
            state_nxt = CH_IDLE;
        end else begin
            unique case (state)
                CH_IDLE, CH_LOAD: state_nxt = CH_RUN;
                CH_RUN:           if (zero_evt && !cc.reload) state_nxt = CH_DONE;
                CH_DONE:          state_nxt = CH_DONE;
                default:          state_nxt = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cc.manual) begin
            cnt <= cnt_buf;
        end else if (running && tick) begin
            if (cnt != '0)      cnt <= cnt - 1'b1;
            else if (cc.reload) cnt <= cnt_buf;
        end
    end
endmodule

// File: rtl/quint_pwm_timer.sv
module quint_pwm_timer
    import qpt_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int DIV_LOG2_MAX = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [4:0]  irq_o,
    output logic [3:0]  pwm_o
);
    logic [15:0]                    cfg0;
    logic [NCH*4-1:0]               cfg1;
    logic [31:0]                    ctrl;
    logic [NCH-1:0][CNT_W-1:0]      cnt_buf, cnt_live;
    logic [NPWM-1:0][CNT_W-1:0]     cmp_buf;
    logic [NCH-1:0]                 irq_en, irq_st, zero_evt, running, tick;
    logic [NCH-1:0]                 start, manual, reload;
    logic [1:0]                     pre_tick;
    logic [1:0][DIV_LOG2_MAX-1:0]   div_cnt;
    logic                           wr_en;

    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg0    <= '0;
            cfg1    <= '0;
            ctrl    <= '0;
            cnt_buf <= '0;
            cmp_buf <= '0;
            irq_en  <= '0;
            irq_st  <= '0;
        end else begin
            if (wr_en && bus_addr == A_CFG0) cfg0 <= bus_wdata[15:0];
            if (wr_en && bus_addr == A_CFG1) cfg1 <= bus_wdata[NCH*4-1:0];
            if (wr_en && bus_addr == A_CTRL) ctrl <= bus_wdata & CTRL_MASK;
            if (wr_en && bus_addr == A_IRQ)  irq_en <= bus_wdata[NCH-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (wr_en && bus_addr == cnt_buf_addr(n))
                    cnt_buf[n] <= bus_wdata[CNT_W-1:0];
                if (zero_evt[n])
                    irq_st[n] <= 1'b1;
                else if (wr_en && bus_addr == A_IRQ && bus_wdata[NCH+n])
                    irq_st[n] <= 1'b0;
            end
            for (int n = 0; n < NPWM; n++) begin
                if (wr_en && bus_addr == cmp_buf_addr(n))
                    cmp_buf[n] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CFG0) bus_rdata = 32'(cfg0);
        if (bus_addr == A_CFG1) bus_rdata = 32'(cfg1);
        if (bus_addr == A_CTRL) bus_rdata = ctrl;
        if (bus_addr == A_IRQ)  bus_rdata = 32'({irq_st, irq_en});
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == cnt_buf_addr(n)) bus_rdata = 32'(cnt_buf[n]);
            if (bus_addr == obs_addr(n))     bus_rdata = 32'(cnt_live[n]);
        end
        for (int n = 0; n < NPWM; n++) begin
            if (bus_addr == cmp_buf_addr(n)) bus_rdata = 32'(cmp_buf[n]);
        end
    end

    assign irq_o = irq_en & irq_st;

    for (genvar g = 0; g < 2; g++) begin : g_pre
        qpt_tick_gen #(.PRE_W(8), .DIV_W(DIV_LOG2_MAX)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .pre_val  (cfg0[8*g +: 8]),
            .pre_tick (pre_tick[g]),
            .div_cnt  (div_cnt[g])
        );
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam int B = ctrl_base(n);
        localparam int G = grp_sel(n);
        ch_ctrl_t cc;

        assign start[n]  = ctrl[B];
        assign manual[n] = ctrl[B+1];
        if (n < NPWM) begin : g_rl
            assign reload[n] = ctrl[B+3];
        end else begin : g_rl_last
            assign reload[n] = ctrl[B+2];
        end
        assign cc = '{start: start[n], manual: manual[n], reload: reload[n]};

        qpt_channel #(.CNT_W(CNT_W), .DIV_W(DIV_LOG2_MAX)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cc       (cc),
            .cnt_buf  (cnt_buf[n]),
            .pre_tick (pre_tick[G]),
            .div_cnt  (div_cnt[G]),
            .div_sel  (cfg1[4*n +: 4]),
            .cnt      (cnt_live[n]),
            .tick     (tick[n]),
            .zero_evt (zero_evt[n]),
            .running  (running[n])
        );

        if (n < NPWM) begin : g_out
            logic [CNT_W-1:0] cmp_live;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         cmp_live <= '0;
                else if (manual[n]) cmp_live <= cmp_buf[n];
            end
            assign pwm_o[n] = (cnt_live[n] > cmp_live) ^ ctrl[B+2];
        end
    end
endmodule

module qpt_checker #(
    parameter int NCH   = 5,
    parameter int CNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [7:0]                 bus_addr,
    input logic [NCH-1:0]             clr_bits,
    input logic [NCH-1:0]             irq_st,
    input logic [NCH-1:0]             zero_evt,
    input logic [NCH-1:0]             running,
    input logic [NCH-1:0]             tick,
    input logic [NCH-1:0]             manual,
    input logic [NCH-1:0]             reload,
    input logic [NCH-1:0][CNT_W-1:0]  cnt_live,
    input logic [NCH-1:0][CNT_W-1:0]  cnt_buf
);
    logic irq_wr;
    assign irq_wr = bus_sel && bus_wr && (bus_addr == 8'h44);

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        assert_status_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            zero_evt[n] |=> irq_st[n]);
        assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (running[n] && tick[n] && cnt_live[n] != '0) |=>
                cnt_live[n] == CNT_W'($past(cnt_live[n]) - 1'b1));
        assert_manual_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            manual[n] |=> cnt_live[n] == $past(cnt_buf[n]));
        assert_auto_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (zero_evt[n] && reload[n]) |=> cnt_live[n] == $past(cnt_buf[n]));
        assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_wr && clr_bits[n] && !zero_evt[n]) |=> !irq_st[n]);
        assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_st[n] && !(irq_wr && clr_bits[n])) |=> irq_st[n]);
        assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (!running[n] && !manual[n]) |=> $stable(cnt_live[n]));
    end
endmodule

bind quint_pwm_timer qpt_checker #(.NCH(5), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .clr_bits (bus_wdata[9:5]),
    .irq_st   (irq_st),
    .zero_evt (zero_evt),
    .running  (running),
    .tick     (tick),
    .manual   (manual),
    .reload   (reload),
    .cnt_live (cnt_live),
    .cnt_buf  (cnt_buf)
);

// File: tb/quint_pwm_timer_tb.sv
`timescale 1ns/1ps
module quint_pwm_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  irq_o;
    logic [3:0]  pwm_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    quint_pwm_timer #(.CNT_W(16), .DIV_LOG2_MAX(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .pwm_o(pwm_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_highs(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o[ch]) hi++;
        end
    endtask

    task automatic measure_period(input int ch, output int per);
        logic prev;
        logic cur;
        int guard;
        guard = 0;
        per = 0;
        @(negedge clk); prev = pwm_o[ch];
        forever begin
            @(negedge clk); cur = pwm_o[ch]; guard++;
            if ((!prev && cur) || guard > 1000) break;
            prev = cur;
        end
        prev = cur;
        forever begin
            @(negedge clk); cur = pwm_o[ch]; per++;
            if ((!prev && cur) || per > 1000) break;
            prev = cur;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        peek(8'h00, d); chk("R1", "cfg0 after reset", d, 0);
        peek(8'h04, d); chk("R1", "cfg1 after reset", d, 0);
        peek(8'h08, d); chk("R1", "ctrl after reset", d, 0);
        peek(8'h44, d); chk("R1", "irq reg after reset", d, 0);
        peek(8'h40, d); chk("R1", "ch4 count after reset", d, 0);
        chk("R1", "irq_o/pwm_o after reset", {23'b0, irq_o, pwm_o}, 0);
    endtask

    task automatic t_layout;
        logic [31:0] d;
        wr(8'h08, 32'hFFFF_FFFF);
        peek(8'h08, d); chk("R7", "ctrl implemented bits", d, 32'h007F_FF0F);
        wr(8'h08, 32'h0);
        peek(8'h08, d); chk("R7", "ctrl cleared", d, 0);
    endtask

    task automatic t_addr_map;
        logic [31:0] d;
        for (int n = 0; n < 5; n++) wr(8'(12 * n + 12), 32'h100 + n);
        for (int n = 0; n < 4; n++) wr(8'(12 * n + 16), 32'h200 + n);
        for (int n = 0; n < 5; n++) begin
            peek(8'(12 * n + 12), d); chk("R11", $sformatf("count buffer ch%0d", n), d, 32'h100 + n);
        end
        for (int n = 0; n < 4; n++) begin
            peek(8'(12 * n + 16), d); chk("R11", $sformatf("compare buffer ch%0d", n), d, 32'h200 + n);
        end
        wr(8'h40, 32'hBEEF);
        peek(8'h3C, d); chk("R11", "ch4 buffer after write to 0x40", d, 32'h104);
        peek(8'h40, d); chk("R11", "ch4 live count after write to 0x40", d, 0);
        wr(8'h14, 32'hAAAA);
        peek(8'h0C, d); chk("R11", "ch0 buffer after write to 0x14", d, 32'h100);
        peek(8'h14, d); chk("R11", "ch0 live count after write to 0x14", d, 0);
    endtask

    task automatic t_manual;
        logic [31:0] d;
        wr(8'h18, 32'h1234);
        wr(8'h08, 32'h300);
        cyc(3);
        peek(8'h20, d); chk("R2", "ch1 loaded by manual update", d, 32'h1234);
        cyc(5);
        peek(8'h20, d); chk("R2", "ch1 held while manual set", d, 32'h1234);
        wr(8'h18, 32'h55);
        cyc(1);
        peek(8'h20, d); chk("R2", "ch1 follows buffer while manual held", d, 32'h55);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_stop;
        logic [31:0] d1, d2;
        wr(8'h08, 32'h100);
        cyc(10);
        wr(8'h08, 32'h0);
        peek(8'h20, d1);
        chk("R3", "ch1 decremented while started", 32'(d1 < 32'h55 && d1 > 32'h40), 1);
        cyc(10);
        peek(8'h20, d2); chk("R12", "ch1 frozen after start cleared", d2, d1);
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        wr(8'h0C, 32'd3);
        wr(8'h44, 32'h1);
        wr(8'h08, 32'h2);
        wr(8'h08, 32'h1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        peek(8'h44, d); chk("R3", "status not yet set after N+1 edges", d[5], 0);
        @(posedge clk); @(negedge clk);
        peek(8'h44, d); chk("R3", "status set after N+2 edges", d[5], 1);
        chk("R9", "irq_o with enable and status", 32'(irq_o), 32'h1);
        cyc(10);
        peek(8'h14, d); chk("R4", "one-shot count stays at zero", d, 0);
        chk("R4", "pwm ch0 low after stop", 32'(pwm_o[0]), 0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        wr(8'h44, 32'h1);
        peek(8'h44, d); chk("R8", "status kept when writing 0", d, 32'h21);
        chk("R9", "irq_o still high", 32'(irq_o[0]), 1);
        wr(8'h44, 32'h21);
        peek(8'h44, d); chk("R8", "status cleared by writing 1", d, 32'h01);
        chk("R9", "irq_o low after clear", 32'(irq_o), 0);
        wr(8'h18, 32'h0);
        wr(8'h08, 32'h200);
        wr(8'h08, 32'h900);
        cyc(3);
        wr(8'h44, 32'h40);
        peek(8'h44, d); chk("R8", "zero tick wins over clear", d[6], 1);
        wr(8'h08, 32'h0);
        wr(8'h44, 32'h40);
        peek(8'h44, d); chk("R8", "ch1 status cleared when idle", d[6], 0);
    endtask

    task automatic t_reload_pwm;
        logic [31:0] d;
        int hi;
        wr(8'h0C, 32'd4);
        wr(8'h10, 32'd1);
        wr(8'h08, 32'h2);
        wr(8'h08, 32'h9);
        cyc(5);
        count_highs(0, 20, hi); chk("R10", "ch0 high cycles (count>compare)", hi, 12);
        wr(8'h44, 32'h20);
        cyc(7);
        peek(8'h44, d); chk("R4", "auto-reload expires again", d[5], 1);
        peek(8'h14, d); chk("R4", "reloaded count within buffer", 32'(d <= 4), 1);
        wr(8'h08, 32'hD);
        cyc(2);
        count_highs(0, 20, hi); chk("R10", "ch0 high cycles when inverted", hi, 8);
    endtask

    task automatic t_prescale;
        int per;
        wr(8'h00, 32'h0200);
        wr(8'h24, 32'd2);
        wr(8'h28, 32'd0);
        wr(8'h08, 32'h200D);
        wr(8'h08, 32'h900D);
        measure_period(2, per); chk("R5", "ch2 period with prescaler B=2", per, 9);
        measure_period(0, per); chk("R5", "ch0 period unaffected by prescaler B", per, 5);
    endtask

    task automatic t_divider;
        int per;
        wr(8'h04, 32'h1000);
        wr(8'h30, 32'd1);
        wr(8'h34, 32'd0);
        wr(8'h08, 32'h2900D);
        wr(8'h08, 32'h9900D);
        measure_period(3, per); chk("R6", "ch3 period with divide-by-2", per, 12);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hF000);
        measure_period(3, per); measure_period(3, per);
        chk("R6", "ch3 period with clamped divider", per, 32);
    endtask

    task automatic t_ch4;
        logic [31:0] d;
        wr(8'h3C, 32'd2);
        wr(8'h08, 32'h29900D);
        wr(8'h08, 32'h59900D);
        cyc(8);
        peek(8'h44, d); chk("R7", "ch4 expires", d[9], 1);
        wr(8'h44, 32'h200);
        cyc(8);
        peek(8'h44, d); chk("R7", "ch4 reload bit at group bit 2", d[9], 1);
        peek(8'h40, d); chk("R7", "ch4 live count bounded by buffer", 32'(d <= 2), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_layout();
        t_addr_map();
        t_manual();
        t_stop();
        t_oneshot();
        t_w1c();
        t_reload_pwm();
        t_prescale();
        t_divider();
        t_ch4();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule